// File: doc/BRIEF.md
# PRBS Bit Error Rate Checker

This block measures bit errors on a serial link whose latency is not known in advance. It holds a local 4-bit linear feedback shift register that produces the same pseudo-random sequence as the transmitter. Each received bit that is marked valid is compared at once with the current local reference bit. Received bits are never stored.

The local generator steps only on cycles where the receive-valid strobe is high. The first valid bit after reset or clear is therefore lined up with the first reference bit, and any gaps in the valid strobe leave the alignment intact. The transmitter repeats its 15-bit period without a break, so the checker can start on the first bit of any period once the receiver front end reports valid data.

Two saturating counters report the mismatched bits and the compared bits. A registered pulse marks each individual mismatch. A synchronous clear restarts the measurement without a full reset.

Top module: `prbs_ber_check`

## Requirements
- R1: While and after a synchronous reset, `err_count` and `bit_count` are 0, `err_pulse` is 0, and the reference register holds the seed 4'b0001.
- R2: The reference bit is the most significant bit of the 4-bit state. Each step computes next = {q[2], q[1], q[0], q[2]^q[3]}. Starting from the seed, the reference bits are 0,0,0,1,0,0,1,1,0,1,0,1,1,1,1, and this 15-bit pattern repeats.
- R3: The reference register steps only on cycles where `rx_valid` is 1. Idle cycles of any length do not change the alignment.
- R4: The first valid bit after reset or clear is compared with the first reference bit of the sequence (0).
- R5: `err_count` rises by exactly 1 on the clock edge that samples a valid bit differing from its reference bit, and it is otherwise unchanged.
- R6: `bit_count` rises by exactly 1 on each clock edge that samples `rx_valid` = 1.
- R7: `err_pulse` is 1 for exactly the one clock that follows a mismatched valid bit, and it is 0 in every other cycle.
- R8: When `clr` is 1 at a clock edge, both counters go to 0, `err_pulse` goes to 0 and the seed is reloaded. A valid bit presented in that same cycle is neither compared nor counted.
- R9: Both counters saturate at their all-ones value (CNT_W bits) instead of wrapping.
- R10: The reference state is never all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous measurement clear, active high |
| rx_bit | input | 1 | Received data bit |
| rx_valid | input | 1 | Marks `rx_bit` as valid in this cycle |
| err_count | output | CNT_W | Number of mismatched bits, saturating |
| bit_count | output | CNT_W | Number of compared bits, saturating |
| err_pulse | output | 1 | High one clock after a mismatched bit |

## Verification
A corrupted reference state, or a state that steps on an idle cycle, shows up as a burst of spurious `err_pulse` and a jump in `err_count`. This happens within the next few valid bits, because a misaligned 15-bit sequence disagrees with itself in most positions. A bad counter shows up on the first valid bit after the fault, as a difference between `bit_count` and the number of valid strobes sent. The bench sends a delayed stream with gaps and injected flips. It checks both counters and the pulse after every cycle, so a fault appears in the cycle where it happens.

// File: rtl/prbs_ber_check.sv
module prbs_ber_check #(
  parameter int          CNT_W = 32,
  parameter logic [3:0]  SEED  = 4'b0001
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             rx_bit,
  input  logic             rx_valid,
  output logic [CNT_W-1:0] err_count,
  output logic [CNT_W-1:0] bit_count,
  output logic             err_pulse
);
  localparam int               LW   = 4;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [LW-1:0] lfsr;

  wire           ref_bit  = lfsr[LW-1];
  wire           miss     = rx_valid & (rx_bit ^ ref_bit);
  wire [LW-1:0]  lfsr_nxt = {lfsr[2:0], lfsr[2] ^ lfsr[3]};
  wire           bit_sat  = (bit_count == CMAX);
  wire           err_sat  = (err_count == CMAX);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lfsr      <= SEED;
      err_count <= '0;
      bit_count <= '0;
      err_pulse <= 1'b0;
    end else begin
      err_pulse <= miss;
      if (rx_valid) begin
        lfsr <= lfsr_nxt;
        if (!bit_sat) bit_count <= bit_count + 1'b1;
        if (miss && !err_sat) err_count <= err_count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/prbs_ber_check_sva.sv
module prbs_ber_check_sva #(
  parameter int         CNT_W = 32,
  parameter logic [3:0] SEED  = 4'b0001
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             rx_bit,
  input logic             rx_valid,
  input logic [CNT_W-1:0] err_count,
  input logic [CNT_W-1:0] bit_count,
  input logic             err_pulse,
  input logic [3:0]       lfsr
);
  AST_STATE_NONZERO: assert property (@(posedge clk) disable iff (rst) lfsr != 4'b0000); // R10
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!clr && !rx_valid) |=> ($stable(lfsr) && $stable(bit_count) && $stable(err_count) && !err_pulse)); // R3
  AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (rst)
    clr |=> (err_count == '0 && bit_count == '0 && lfsr == SEED && !err_pulse)); // R8
  AST_MISS_PULSE: assert property (@(posedge clk) disable iff (rst)
    (!clr && rx_valid && (rx_bit != lfsr[3])) |=> err_pulse); // R7
  AST_ERR_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (err_count >= $past(err_count))); // R5
  AST_ERR_LE_BITS: assert property (@(posedge clk) disable iff (rst) err_count <= bit_count); // R6
  AST_PULSE_ON_ERR: assert property (@(posedge clk) disable iff (rst)
    (err_pulse && !$past(clr) && $past(err_count) != '1) |-> (err_count == $past(err_count) + 1'b1)); // R5
endmodule

bind prbs_ber_check prbs_ber_check_sva #(.CNT_W(CNT_W), .SEED(SEED)) chk (
  .clk(clk), .rst(rst), .clr(clr), .rx_bit(rx_bit), .rx_valid(rx_valid),
  .err_count(err_count), .bit_count(bit_count), .err_pulse(err_pulse), .lfsr(lfsr)
);

// File: tb/prbs_ber_check_test.sv
module prbs_ber_check_test;
  localparam int SAT_W = 3;
  localparam logic [14:0] SEQ = 15'b000100110101111;
  localparam int NV = 40;
  // each entry: {valid, flip}
  localparam logic [1:0] VEC [NV] = '{
    2'b10, 2'b10, 2'b10, 2'b00, 2'b10, 2'b11, 2'b10, 2'b00,
    2'b00, 2'b00, 2'b10, 2'b10, 2'b11, 2'b11, 2'b10, 2'b00,
    2'b10, 2'b10, 2'b10, 2'b01, 2'b10, 2'b10, 2'b11, 2'b10,
    2'b00, 2'b10, 2'b10, 2'b10, 2'b10, 2'b11, 2'b00, 2'b11,
    2'b10, 2'b10, 2'b10, 2'b10, 2'b00, 2'b10, 2'b11, 2'b10
  };

  logic clk = 1'b0;
  logic rst = 1'b1, clr = 1'b0, rx_bit = 1'b0, rx_valid = 1'b0;
  logic [31:0] err_count, bit_count;
  logic        err_pulse;
  logic [SAT_W-1:0] s_err, s_bits;
  logic             s_pulse;

  int checks = 0, fails = 0;
  int exp_err = 0, exp_bits = 0, idx = 0;
  logic exp_pulse = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prbs_ber_check uut (.clk(clk), .rst(rst), .clr(clr), .rx_bit(rx_bit), .rx_valid(rx_valid),
    .err_count(err_count), .bit_count(bit_count), .err_pulse(err_pulse));
  prbs_ber_check #(.CNT_W(SAT_W)) uut_sat (.clk(clk), .rst(rst), .clr(clr), .rx_bit(rx_bit),
    .rx_valid(rx_valid), .err_count(s_err), .bit_count(s_bits), .err_pulse(s_pulse));

  function automatic int satv(int v);
    return (v > 7) ? 7 : v;
  endfunction

  task automatic check(string req);
    checks++;
    if (err_count !== 32'(exp_err) || bit_count !== 32'(exp_bits) || err_pulse !== exp_pulse) begin
      fails++;
      $display("FAIL %s: err=%0d bits=%0d pulse=%b expected err=%0d bits=%0d pulse=%b",
               req, err_count, bit_count, err_pulse, exp_err, exp_bits, exp_pulse);
    end
    if (s_err !== SAT_W'(satv(exp_err)) || s_bits !== SAT_W'(satv(exp_bits))) begin
      fails++;
      $display("FAIL R9: sat err=%0d bits=%0d expected err=%0d bits=%0d",
               s_err, s_bits, satv(exp_err), satv(exp_bits));
    end
  endtask

  task automatic step(bit v, bit f, bit c, string req);
    @(negedge clk);
    rx_valid = v;
    clr      = c;
    rx_bit   = SEQ[14 - idx] ^ f;
    @(posedge clk);
    #2;
    if (c) begin
      exp_err = 0; exp_bits = 0; idx = 0; exp_pulse = 1'b0;
    end else if (v) begin
      exp_bits++;
      if (f) exp_err++;
      exp_pulse = f;
      idx = (idx + 1) % 15;
    end else exp_pulse = 1'b0;
    check(req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rx_valid = 1'b0; clr = 1'b0;
    @(posedge clk); @(posedge clk); #2;
    exp_err = 0; exp_bits = 0; idx = 0; exp_pulse = 1'b0;
    check("R1 reset");
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    do_reset();
    // link latency: idle before the first valid bit (R4)
    for (int i = 0; i < 7; i++) step(1'b0, 1'b0, 1'b0, "R3 idle latency");
    for (int i = 0; i < NV; i++) step(VEC[i][1], VEC[i][0], 1'b0, "R2/R5/R6/R7 vector");
    // clear with a wrong valid bit in the same cycle: ignored (R8)
    step(1'b1, 1'b1, 1'b1, "R8 clear");
    step(1'b1, 1'b0, 1'b0, "R4 first bit after clear");
    // two full clean periods: no errors expected (R2, R10)
    for (int i = 0; i < 30; i++) step(1'b1, 1'b0, 1'b0, "R10 clean periods");
    // long run of flips drives the narrow counters into saturation (R9)
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b0, "R9 saturate");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, "R7 pulse drops");
    // mid-run reset and restart with the first bit flipped
    do_reset();
    step(1'b1, 1'b1, 1'b0, "R4 first bit after reset");
    step(1'b1, 1'b0, 1'b0, "R2 second bit");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule